// File: doc/BRIEF.md
# Dual-Mode Waveform Timer Channel

One counter channel of a programmable interval timer. A down-counter is preset from a 16-bit value supplied by the surrounding register logic. It counts on a chosen step source and produces a square-wave or single-pulse waveform on an output pin. A one-cycle timeout pulse marks every pass through the all-zeros count, and a sticky flag records that a timeout has happened. The counter runs either as one 16-bit count or as two cascaded 8-bit counts. In the cascaded form the low byte sets the width of the high phase and the product of both bytes sets the repetition period.

Steps come either from an internal enable pulse in the system clock domain or from falling edges of an external active-low clock. That clock is first brought through a synchronizer. An optional divide-by-8 stage, present when the channel is built with it, sits in front of the counter. The counter is restarted by a hold/preset input, by a synchronized falling edge of an active-low gate, or, when the control word permits, by a write of a new preset value.

Top module: `wave_timer_chan`

## Requirements
- R1: While `rst_n` is low (asynchronous), `count`, `timeout`, `wave_out` and `irq_flag` are all 0.
- R2: Initialization loads `latch_val` into `count` one edge after any of: `hold_preset` high (level, it wins over steps), a gate falling edge (visible on the third rising edge after `gate_n` falls), or a `latch_wr` pulse when ctrl bit 4 is 0. With ctrl bit 4 = 1, `latch_wr` leaves `count` unchanged.
- R3: ctrl bit 1 = 1 takes steps from `tick_en` (one per high cycle); ctrl bit 1 = 0 takes steps from falling edges of `ext_clk_n`, which change `count` on the third rising edge after the fall. The unselected source has no effect.
- R4: With ctrl bit 2 = 0 the count drops by one per step. A step that finds all zeros reloads N = `latch_val` and raises `timeout`, so timeouts come every N+1 steps.
- R5: In 16-bit continuous mode (ctrl bit 5 = 0), `wave_out` is low after initialization and toggles at every timeout: N+1 steps low, then N+1 steps high.
- R6: With ctrl bit 2 = 1, M = `latch_val[15:8]` and L = `latch_val[7:0]`. The low byte runs L..0, and at 0 it reloads L while the high byte decrements. Timeouts come every (L+1)(M+1) steps. The pin is high only while the high byte is 0 and the low byte is not, which gives L steps high and M(L+1)+1 steps low per period (M=3, L=4: 4 high, 16 low).
- R7: In 16-bit single-shot mode (ctrl bit 5 = 1) the pin is low for the first step after initialization, high for the next N steps, and low from the timeout until the next initialization. Counting and timeouts continue.
- R8: In dual single-shot mode the pin follows R6 until the first timeout, then stays low until the next initialization.
- R9: `irq_flag` is set by a timeout step and cleared by an initialization or by any `latch_wr`; clearing wins over setting.
- R10: ctrl bit 7 = 0 holds `wave_out` low whatever the count.
- R11: With the prescaler built in and ctrl bit 0 = 1, a step happens on every 8th source pulse, and the divider restarts at initialization. With bit 0 = 0 every source pulse is a step.
- R12: `timeout` is high for exactly one cycle per terminal step, in the cycle in which `count` shows the reloaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Internal step enable pulse |
| ext_clk_n | input | 1 | External active-low count clock, asynchronous |
| gate_n | input | 1 | Active-low gate, falling edge restarts the count |
| hold_preset | input | 1 | Holds the counter at the preset value |
| latch_wr | input | 1 | Strobe: new preset value written |
| ctrl | input | 8 | Control word (bits 0,1,2,4,5,7 used) |
| latch_val | input | CNT_W | Preset value N, or {M,L} in dual mode |
| count | output | CNT_W | Current counter value |
| timeout | output | 1 | One-cycle pulse at each terminal step |
| wave_out | output | 1 | Waveform output pin |
| irq_flag | output | 1 | Sticky timeout flag |

## Verification
Every counter, waveform, timeout and flag result is due on the first rising edge after the `tick_en` cycle, `hold_preset` cycle or `latch_wr` cycle that causes it. Results from a falling edge on `gate_n` or `ext_clk_n` are due only on the third edge, after two synchronizer stages and the edge register. The bench drives every input on the falling clock edge and samples on the next falling edge, so each sample sees exactly one rising edge of effect. For the synchronized inputs it checks that nothing has changed after the first and second edges and that the change is present after the third. Because `timeout` lasts one cycle, it is sampled at the falling edge straight after the step, before any idle cycles are inserted.

// File: rtl/twc_pkg.sv
`timescale 1ns/1ps
package twc_pkg;
  // control word bit positions
  localparam int CB_PRESCALE = 0;
  localparam int CB_INTCLK   = 1;
  localparam int CB_DUAL     = 2;
  localparam int CB_NOWRINIT = 4;
  localparam int CB_ONESHOT  = 5;
  localparam int CB_OUTEN    = 7;

  typedef struct packed {
    logic out_en;
    logic one_shot;
    logic no_wr_init;
    logic dual;
    logic int_clk;
    logic prescale;
  } twc_mode_t;

  function automatic twc_mode_t twc_decode(input logic [7:0] c);
    twc_mode_t m;
    m.out_en     = c[CB_OUTEN];
    m.one_shot   = c[CB_ONESHOT];
    m.no_wr_init = c[CB_NOWRINIT];
    m.dual       = c[CB_DUAL];
    m.int_clk    = c[CB_INTCLK];
    m.prescale   = c[CB_PRESCALE];
    return m;
  endfunction
endpackage

// File: rtl/twc_sync_fall.sv
`timescale 1ns/1ps
module twc_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic fall
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              last_q, last_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], async_n};
    end else begin : g_single
      always_comb chain_d = async_n;
    end
  endgenerate

  always_comb last_d = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      last_q  <= last_d;
    end
  end

  assign fall = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/twc_prescale.sv
`timescale 1ns/1ps
module twc_prescale #(
  parameter int DIV     = 8,
  parameter bit PRESENT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic use_div,
  input  logic restart,
  output logic step
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST  = PW'(DIV - 1);
  localparam logic [PW-1:0] ONE_P = PW'(1);

  generate
    if (PRESENT) begin : g_div
      logic [PW-1:0] ph_q, ph_d;
      logic          wrap;

      assign wrap = (ph_q == LAST);

      always_comb begin
        ph_d = ph_q;
        if (restart)
          ph_d = '0;
        else if (src && use_div)
          ph_d = wrap ? '0 : ph_q + ONE_P;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
      end

      assign step = use_div ? (src & wrap) : src;

      AST_STEP_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> src); // R11
      AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ph_q == '0)); // R11
    end else begin : g_pass
      logic unused_pre;
      assign unused_pre = ^{clk, rst_n, use_div, restart};
      assign step = src;
    end
  endgenerate
endmodule

// File: rtl/twc_count_core.sv
`timescale 1ns/1ps
module twc_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             init,
  input  logic             dual,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             term,
  output logic             to_pulse,
  output logic             hi_zero,
  output logic             lo_zero
);
  localparam int HALF = CNT_W / 2;
  localparam logic [HALF-1:0]  ONE_H = HALF'(1);
  localparam logic [CNT_W-1:0] ONE_F = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             to_q, to_d;
  logic             all_zero;

  assign all_zero = (cnt_q == '0);
  assign term     = step & ~init & all_zero;

  always_comb begin
    cnt_d = cnt_q;
    to_d  = 1'b0;
    if (init) begin
      cnt_d = load_val;
    end else if (step) begin
      if (all_zero) begin
        cnt_d = load_val;
        to_d  = 1'b1;
      end else if (!dual) begin
        cnt_d = cnt_q - ONE_F;
      end else if (cnt_q[HALF-1:0] == '0) begin
        cnt_d = {cnt_q[CNT_W-1:HALF] - ONE_H, load_val[HALF-1:0]};
      end else begin
        cnt_d = {cnt_q[CNT_W-1:HALF], cnt_q[HALF-1:0] - ONE_H};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      to_q  <= to_d;
    end
  end

  assign cnt      = cnt_q;
  assign to_pulse = to_q;
  assign hi_zero  = (cnt_q[CNT_W-1:HALF] == '0);
  assign lo_zero  = (cnt_q[HALF-1:0] == '0);

  AST_INIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (cnt_q == $past(load_val))); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !step) |=> $stable(cnt_q)); // R3
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !init && !dual && !all_zero) |=> (cnt_q == $past(cnt_q) - ONE_F)); // R4
  AST_TO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |-> (cnt_q == $past(load_val))); // R12
endmodule

// File: rtl/twc_wave.sv
`timescale 1ns/1ps
module twc_wave (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic step,
  input  logic term,
  input  logic clr_flag,
  input  logic one_shot,
  input  logic dual,
  input  logic out_en,
  input  logic hi_zero,
  input  logic lo_zero,
  output logic pin,
  output logic flag
);
  logic wave_q, wave_d;
  logic armed_q, armed_d;
  logic flag_q, flag_d;
  logic dual_lvl;

  always_comb begin
    wave_d  = wave_q;
    armed_d = armed_q;
    if (init) begin
      wave_d  = 1'b0;
      armed_d = 1'b1;
    end else if (step) begin
      if (term) begin
        armed_d = 1'b0;
        wave_d  = one_shot ? 1'b0 : ~wave_q;
      end else if (one_shot && armed_q) begin
        wave_d = 1'b1;
      end
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (clr_flag)  flag_d = 1'b0;
    else if (term) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q  <= 1'b0;
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      wave_q  <= wave_d;
      armed_q <= armed_d;
      flag_q  <= flag_d;
    end
  end

  assign dual_lvl = hi_zero & ~lo_zero & (~one_shot | armed_q);
  assign pin      = out_en & (dual ? dual_lvl : wave_q);
  assign flag     = flag_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !clr_flag) |=> flag_q); // R9
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flag |=> !flag_q); // R9
  AST_SHOT_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (term && one_shot) |=> (!pin || !one_shot)); // R7
  AST_INIT_LOW16: assert property (@(posedge clk) disable iff (!rst_n)
    (init && !dual) |=> (!pin || dual)); // R5
endmodule

// File: rtl/wave_timer_chan.sv
`timescale 1ns/1ps
module wave_timer_chan
  import twc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_DIV     = 8,
  parameter bit PRESCALE_EN = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ext_clk_n,
  input  logic             gate_n,
  input  logic             hold_preset,
  input  logic             latch_wr,
  input  logic [7:0]       ctrl,
  input  logic [CNT_W-1:0] latch_val,
  output logic [CNT_W-1:0] count,
  output logic             timeout,
  output logic             wave_out,
  output logic             irq_flag
);
  twc_mode_t mode;
  logic gate_fall, ext_fall, src_pulse, step;
  logic init, clr_flag, term, hi_zero, lo_zero;
  logic unused_ctrl;

  assign mode        = twc_decode(ctrl);
  assign unused_ctrl = ^{ctrl[3], ctrl[6]};

  twc_sync_fall #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .async_n(gate_n), .fall(gate_fall));

  twc_sync_fall #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .async_n(ext_clk_n), .fall(ext_fall));

  assign init      = hold_preset | gate_fall | (latch_wr & ~mode.no_wr_init);
  assign clr_flag  = init | latch_wr;
  assign src_pulse = mode.int_clk ? tick_en : ext_fall;

  twc_prescale #(.DIV(PRE_DIV), .PRESENT(PRESCALE_EN)) u_pre (
    .clk(clk), .rst_n(rst_n), .src(src_pulse), .use_div(mode.prescale),
    .restart(init), .step(step));

  twc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .init(init), .dual(mode.dual),
    .load_val(latch_val), .cnt(count), .term(term), .to_pulse(timeout),
    .hi_zero(hi_zero), .lo_zero(lo_zero));

  twc_wave u_wave (
    .clk(clk), .rst_n(rst_n), .init(init), .step(step), .term(term),
    .clr_flag(clr_flag), .one_shot(mode.one_shot), .dual(mode.dual),
    .out_en(mode.out_en), .hi_zero(hi_zero), .lo_zero(lo_zero),
    .pin(wave_out), .flag(irq_flag));

  AST_MASKED_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.out_en) |-> !wave_out); // R10
  AST_HOLD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_preset |=> (count == $past(latch_val) && !timeout)); // R2
endmodule

// File: tb/wave_timer_chan_bench.sv
`timescale 1ns/1ps
module wave_timer_chan_bench;
  logic        clk, rst_n, tick_en, ext_clk_n, gate_n, hold_preset, latch_wr;
  logic [7:0]  ctrl;
  logic [15:0] latch_val, count;
  logic        timeout, wave_out, irq_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit s_to, s_wave, s_flag;
  int s_cnt;

  wave_timer_chan u_wave_timer_chan (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_clk_n(ext_clk_n),
    .gate_n(gate_n), .hold_preset(hold_preset), .latch_wr(latch_wr),
    .ctrl(ctrl), .latch_val(latch_val), .count(count), .timeout(timeout),
    .wave_out(wave_out), .irq_flag(irq_flag));

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  initial begin
    #3000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_ctrl(input bit oe, input bit os, input bit nowr,
                                         input bit du, input bit ic, input bit pre);
    logic [7:0] c;
    c = 8'h00;
    c[7] = oe; c[5] = os; c[4] = nowr; c[2] = du; c[1] = ic; c[0] = pre;
    return c;
  endfunction

  function automatic int f_period(input bit du, input logic [15:0] v);
    if (du) return (int'(v[7:0]) + 1) * (int'(v[15:8]) + 1);
    return int'(v) + 1;
  endfunction

  function automatic int f_cnt(input bit du, input logic [15:0] v, input int k);
    int pos;
    int lw;
    pos = k % f_period(du, v);
    if (!du) return int'(v) - pos;
    lw = int'(v[7:0]) + 1;
    return ((int'(v[15:8]) - pos / lw) << 8) | (int'(v[7:0]) - pos % lw);
  endfunction

  function automatic bit f_to(input bit du, input logic [15:0] v, input int k);
    return (k > 0) && (k % f_period(du, v) == 0);
  endfunction

  function automatic bit f_wave(input bit os, input bit du, input logic [15:0] v,
                                input int k, input bit oe);
    int p, pos, hi, lo, lw;
    if (!oe) return 1'b0;
    p = f_period(du, v);
    pos = k % p;
    if (du) begin
      if (os && k >= p) return 1'b0;
      lw = int'(v[7:0]) + 1;
      hi = int'(v[15:8]) - pos / lw;
      lo = int'(v[7:0]) - pos % lw;
      return (hi == 0) && (lo != 0);
    end
    if (os) return (k >= 1) && (k <= int'(v));
    return ((k / p) % 2) == 1;
  endfunction

  task automatic init_chan(input logic [7:0] c, input logic [15:0] v);
    ctrl = c;
    latch_val = v;
    hold_preset = 1'b1;
    @(negedge clk);
    hold_preset = 1'b0;
  endtask

  task automatic step_tick(input bit idle_en);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    s_to = timeout; s_wave = wave_out; s_flag = irq_flag; s_cnt = int'(count);
    if (idle_en) repeat ($urandom_range(2)) @(negedge clk);
  endtask

  task automatic run_mode(input bit os, input bit du, input logic [15:0] v,
                          input int steps, input bit oe);
    bit fl;
    string wtag, ctag;
    ctag = du ? "R6 count" : "R4 count";
    if (!oe) wtag = "R10 masked pin";
    else if (os && du) wtag = "R8 dual single-shot pin";
    else if (os) wtag = "R7 single-shot pin";
    else if (du) wtag = "R6 dual pin";
    else wtag = "R5 continuous pin";
    init_chan(mk_ctrl(oe, os, 1'b0, du, 1'b1, 1'b0), v);
    chk_eq("R2 preset load", int'(count), int'(v));
    fl = 1'b0;
    for (int k = 1; k <= steps; k++) begin
      step_tick(1'b1);
      fl = fl | f_to(du, v, k);
      chk_eq(ctag, s_cnt, f_cnt(du, v, k));
      chk_eq("R4 R12 timeout", int'(s_to), int'(f_to(du, v, k)));
      chk_eq(wtag, int'(s_wave), int'(f_wave(os, du, v, k, oe)));
      chk_eq("R9 flag", int'(s_flag), int'(fl));
    end
  endtask

  initial begin
    int hi_run;
    void'($urandom(32'h5eed1234));
    rst_n = 1'b0; tick_en = 1'b0; ext_clk_n = 1'b1; gate_n = 1'b1;
    hold_preset = 1'b0; latch_wr = 1'b0; ctrl = 8'h00; latch_val = 16'h0000;
    repeat (3) @(negedge clk);
    chk_eq("R1 reset count", int'(count), 0);
    chk_eq("R1 reset timeout", int'(timeout), 0);
    chk_eq("R1 reset pin", int'(wave_out), 0);
    chk_eq("R1 reset flag", int'(irq_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_mode(1'b0, 1'b0, 16'd0, 5, 1'b1);
    run_mode(1'b1, 1'b0, 16'd0, 4, 1'b1);
    run_mode(1'b0, 1'b0, 16'd6, 22, 1'b1);
    run_mode(1'b1, 1'b0, 16'd5, 15, 1'b1);
    run_mode(1'b0, 1'b1, 16'h0200, 10, 1'b1);
    run_mode(1'b0, 1'b1, 16'h0003, 10, 1'b1);
    run_mode(1'b1, 1'b1, 16'h0102, 14, 1'b1);
    run_mode(1'b0, 1'b0, 16'd3, 12, 1'b0);
    run_mode(1'b0, 1'b1, 16'h0001, 6, 1'b0);

    // R6 example: M=3, L=4 -> 4 high, 16 low per period
    init_chan(mk_ctrl(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0), 16'h0304);
    hi_run = 0;
    for (int k = 1; k <= 40; k++) begin
      step_tick(1'b0);
      if (k > 20 && s_wave) hi_run++;
    end
    chk_eq("R6 high steps per period", hi_run, 4);
    chk_eq("R6 low steps per period", 20 - hi_run, 16);

    // random mix
    for (int i = 0; i < 14; i++) begin
      bit os, du;
      logic [15:0] v;
      os = 1'($urandom_range(1));
      du = 1'($urandom_range(1));
      if (du) v = {8'($urandom_range(5)), 8'($urandom_range(5))};
      else    v = 16'($urandom_range(24));
      run_mode(os, du, v, 2 * f_period(du, v) + 1, 1'b1);
    end

    // R12: single-cycle timeout, reload visible in the same cycle
    init_chan(mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0), 16'd1);
    step_tick(1'b0);
    step_tick(1'b0);
    chk_eq("R12 timeout high", int'(s_to), 1);
    chk_eq("R12 reload value", s_cnt, 1);
    @(negedge clk);
    chk_eq("R12 timeout one cycle", int'(timeout), 0);

    // R2: latch write reinitializes when bit 4 = 0
    init_chan(mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0), 16'd10);
    repeat (3) step_tick(1'b0);
    latch_val = 16'd20; latch_wr = 1'b1;
    @(negedge clk);
    latch_wr = 1'b0;
    chk_eq("R2 write reload", int'(count), 20);

    // R2 R9: bit 4 = 1, write does not reload but clears flag
    init_chan(mk_ctrl(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0), 16'd5);
    repeat (6) step_tick(1'b0);
    chk_eq("R9 flag after timeout", int'(irq_flag), 1);
    latch_val = 16'd30; latch_wr = 1'b1;
    @(negedge clk);
    latch_wr = 1'b0;
    chk_eq("R2 write ignored for count", int'(count), 5);
    chk_eq("R9 write clears flag", int'(irq_flag), 0);

    // R2: hold wins over steps
    latch_val = 16'd12; hold_preset = 1'b1; tick_en = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk_eq("R2 hold priority", int'(count), 12);
    end
    hold_preset = 1'b0; tick_en = 1'b0;
    @(negedge clk);

    // R2: gate falling edge with synchronizer latency
    init_chan(mk_ctrl(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0), 16'd9);
    repeat (4) step_tick(1'b0);
    gate_n = 1'b0;
    @(negedge clk);
    chk_eq("R2 gate edge 1", int'(count), 5);
    @(negedge clk);
    chk_eq("R2 gate edge 2", int'(count), 5);
    @(negedge clk);
    chk_eq("R2 gate edge 3 reload", int'(count), 9);
    gate_n = 1'b1;
    repeat (3) @(negedge clk);
    step_tick(1'b0);
    repeat (4) @(negedge clk);
    chk_eq("R2 gate rise no reload", int'(count), 8);

    // R3: external clock source
    init_chan(mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 16'd10);
    repeat (3) step_tick(1'b0);
    chk_eq("R3 tick ignored", int'(count), 10);
    ext_clk_n = 1'b0;
    @(negedge clk);
    chk_eq("R3 ext edge 1", int'(count), 10);
    @(negedge clk);
    chk_eq("R3 ext edge 2", int'(count), 10);
    @(negedge clk);
    chk_eq("R3 ext edge 3 step", int'(count), 9);
    repeat (2) @(negedge clk);
    chk_eq("R3 low level one step", int'(count), 9);
    for (int p = 0; p < 3; p++) begin
      ext_clk_n = 1'b1;
      repeat (3) @(negedge clk);
      ext_clk_n = 1'b0;
      repeat (3) @(negedge clk);
    end
    ext_clk_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_eq("R3 ext pulses", int'(count), 6);

    // R11: prescaler
    init_chan(mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1), 16'd20);
    repeat (7) step_tick(1'b1);
    chk_eq("R11 seven pulses", s_cnt, 20);
    step_tick(1'b1);
    chk_eq("R11 eighth pulse", s_cnt, 19);
    repeat (8) step_tick(1'b1);
    chk_eq("R11 sixteenth pulse", s_cnt, 18);
    init_chan(mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0), 16'd20);
    step_tick(1'b0);
    chk_eq("R11 undivided", s_cnt, 19);

    // R1: asynchronous reset mid-run
    init_chan(mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0), 16'd2);
    repeat (4) step_tick(1'b0);
    rst_n = 1'b0;
    #1;
    chk_eq("R1 async count", int'(count), 0);
    chk_eq("R1 async pin", int'(wave_out), 0);
    chk_eq("R1 async flag", int'(irq_flag), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule